// File: doc/BRIEF.md
# PWM Interrupt Status Aggregator

This block gathers the interrupt requests of four PWM generators and the fault conditions of those same generators into a single 32-bit raw status word. A programmable enable word masks the raw status to form a masked status word, and any surviving bit raises one registered interrupt line toward the interrupt controller. Software reaches the block through a small register port: a two-bit address, a write strobe with a data word, and a combinational read-data word.

Each generator has a fault mode input. In latched mode the fault flag captures a fault and keeps it until software clears it with a write-one-to-clear. In live mode the flag simply follows the fault input and clear writes for it are ignored. The generator request flags always mirror their inputs and are never cleared here; they are cleared inside the generators.

Top module: `pwm_irq_agg`

## Requirements
- R1: Address 1 reads the raw status word, which shows every active source whether or not that source is enabled.
- R2: Raw and enable words use bits 0..3 for generator requests 0..3 and bits 16..19 for faults 0..3; all other bits read as zero, and address 3 reads zero and ignores writes.
- R3: After reset the raw fault flags, the enable word and the interrupt output are all zero.
- R4: With a generator's latch-mode input at 1, its fault flag is set by a fault sampled at a clock edge and stays set after the fault input returns to 0.
- R5: With latch mode at 1, writing a 1 to bit 16+n at address 2 clears fault flag n from the following clock edge.
- R6: With latch mode at 0, raw fault bit n equals the present fault input n, and a clear write to bit 16+n has no effect.
- R7: Raw bits 0..3 equal the generator request inputs and are not affected by writes to address 2.
- R8: Address 2 reads raw status AND enable; the interrupt output is the OR of the masked bits, delayed by one clock.
- R9: In latch mode a fault sampled in the same cycle as a clear write for that flag wins, and the flag stays 1.
- R10: Address 0 is the read/write enable word; writing 0 to a clear bit leaves that flag unchanged, and bits outside the valid positions are dropped on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 enable, 1 raw, 2 masked / clear, 3 unused |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr |
| genIrq | input | 4 | Interrupt request from each generator |
| faultIn | input | 4 | Fault condition for each generator |
| latchMode | input | 4 | Per-generator fault mode: 1 latched, 0 live |
| irqOut | output | 1 | Combined interrupt to the interrupt controller |

## Verification
The assertions assume the latch-mode inputs are quasi-static: the hold and set-wins properties compare a flag against the mode seen in the cycle before, so a mode change between those cycles is outside what they describe. The stimulus changes latch mode only while the affected fault input is low and its flag is clear, and it drives every input on the falling edge so each register samples a settled value. The read checks assume the address is stable for the cycle being observed, which the directed tasks keep.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic    enWr;   // write enable word
    logic    clrWr;  // write-one-to-clear fault flags
    regSel_t rdSel;  // read mux select
  } ctrlStrb_t;

endpackage

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl
  import pwm_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  output ctrlStrb_t  strb
);

  regSel_t sel;

  always_comb begin
    sel        = regSel_t'(regAddr);
    strb.rdSel = sel;
    strb.enWr  = wrEn && (sel == SEL_ENABLE);
    strb.clrWr = wrEn && (sel == SEL_MASKED);
  end

endmodule

// File: rtl/pwm_irq_dp.sv
module pwm_irq_dp
  import pwm_irq_pkg::*;
#(
  parameter int NUM_GEN   = 4,
  parameter int DATA_W    = 32,
  parameter int FAULT_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_GEN-1:0] genIrq,
  input  logic [NUM_GEN-1:0] faultIn,
  input  logic [NUM_GEN-1:0] latchMode,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam logic [DATA_W-1:0] LOW_MASK   = (DATA_W)'((64'd1 << NUM_GEN) - 64'd1);
  localparam logic [DATA_W-1:0] VALID_MASK = LOW_MASK | (LOW_MASK << FAULT_LSB);

  logic [DATA_W-1:0]  enQ;
  logic [NUM_GEN-1:0] flagQ;
  logic [NUM_GEN-1:0] rawFault;
  logic [DATA_W-1:0]  rawWord;
  logic [DATA_W-1:0]  maskedWord;
  logic               irqQ;

  // enable word, only valid positions are stored
  always_ff @(posedge clk) begin
    if (!rstN)          enQ <= '0;
    else if (strb.enWr) enQ <= wrData & VALID_MASK;
  end

  // per-generator fault flag
  for (genvar i = 0; i < NUM_GEN; i++) begin : g_fault
    logic clrBit;
    assign clrBit = strb.clrWr && wrData[FAULT_LSB+i];

    always_ff @(posedge clk) begin
      if (!rstN)             flagQ[i] <= 1'b0;
      else if (latchMode[i]) flagQ[i] <= faultIn[i] | (flagQ[i] & ~clrBit);
      else                   flagQ[i] <= faultIn[i];
    end

    assign rawFault[i] = latchMode[i] ? flagQ[i] : faultIn[i];

    // latched flag holds without a clear
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      (latchMode[i] && flagQ[i] && !clrBit) |=> flagQ[i]);

    // latched flag drops after a clear with no fault
    assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      (latchMode[i] && clrBit && !faultIn[i]) |=> !flagQ[i]);

    // a fault beats a simultaneous clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      (latchMode[i] && faultIn[i] && clrBit) |=> flagQ[i]);
  end

  always_comb begin
    rawWord                       = '0;
    rawWord[NUM_GEN-1:0]          = genIrq;
    rawWord[FAULT_LSB +: NUM_GEN] = rawFault;
    maskedWord                    = rawWord & enQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |maskedWord;
  end

  assign irqOut = irqQ;

  always_comb begin
    unique case (strb.rdSel)
      SEL_ENABLE: rdData = enQ;
      SEL_RAW:    rdData = rawWord;
      SEL_MASKED: rdData = maskedWord;
      default:    rdData = '0;
    endcase
  end

  // enable word never holds reserved bits
  assert_enable_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enQ & ~VALID_MASK) == '0);

  // with nothing enabled the output stays low
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |=> !irqOut);

endmodule

// File: rtl/pwm_irq_agg.sv
module pwm_irq_agg
  import pwm_irq_pkg::*;
#(
  parameter int NUM_GEN   = 4,
  parameter int DATA_W    = 32,
  parameter int FAULT_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_GEN-1:0] genIrq,
  input  logic [NUM_GEN-1:0] faultIn,
  input  logic [NUM_GEN-1:0] latchMode,
  output logic               irqOut
);

  localparam logic [DATA_W-1:0] LOW_MASK   = (DATA_W)'((64'd1 << NUM_GEN) - 64'd1);
  localparam logic [DATA_W-1:0] VALID_MASK = LOW_MASK | (LOW_MASK << FAULT_LSB);

  ctrlStrb_t strb;

  pwm_irq_ctrl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  pwm_irq_dp #(
    .NUM_GEN   (NUM_GEN),
    .DATA_W    (DATA_W),
    .FAULT_LSB (FAULT_LSB)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .genIrq    (genIrq),
    .faultIn   (faultIn),
    .latchMode (latchMode),
    .rdData    (rdData),
    .irqOut    (irqOut)
  );

  // reserved positions always read zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~VALID_MASK) == '0);

  // raw generator bits mirror their inputs
  assert_gen_mirror_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd1) |-> (rdData[NUM_GEN-1:0] == genIrq));

  for (genvar i = 0; i < NUM_GEN; i++) begin : g_live
    // live mode fault bit follows the input
    assert_live_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
      (regAddr == 2'd1 && !latchMode[i]) |-> (rdData[FAULT_LSB+i] == faultIn[i]));
  end

endmodule

// File: tb/pwm_irq_agg_tb.sv
`timescale 1ns/1ps
module pwm_irq_agg_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  regAddr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [3:0]  genIrq;
  logic [3:0]  faultIn;
  logic [3:0]  latchMode;
  logic        irqOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwm_irq_agg u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .regAddr   (regAddr),
    .wrData    (wrData),
    .rdData    (rdData),
    .genIrq    (genIrq),
    .faultIn   (faultIn),
    .latchMode (latchMode),
    .irqOut    (irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; read is combinational
  task automatic rdChk(input string req, input logic [1:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.5;
    chk(req, rdData, exp);
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic tReset();
    rdChk("R3 enable after reset", 2'd0, 32'h0);
    rdChk("R3 raw after reset",    2'd1, 32'h0);
    rdChk("R3 masked after reset", 2'd2, 32'h0);
    chk("R3 irqOut after reset", {31'd0, irqOut}, 32'h0);
  endtask

  task automatic tGenMirror();
    @(negedge clk); genIrq = 4'b1010;
    rdChk("R1 raw shows disabled sources", 2'd1, 32'h0000_000A);
    @(negedge clk);
    chk("R1 no irq while disabled", {31'd0, irqOut}, 32'h0);
    doWrite(2'd2, 32'h000F_000F);
    rdChk("R7 clear does not touch gen bits", 2'd1, 32'h0000_000A);
  endtask

  task automatic tEnable();
    doWrite(2'd0, 32'hFFFF_FFFF);
    rdChk("R10 R2 enable keeps valid bits", 2'd0, 32'h000F_000F);
    rdChk("R8 masked = raw & enable", 2'd2, 32'h0000_000A);
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irqOut}, 32'h1);
    doWrite(2'd0, 32'h0000_0004);
    rdChk("R8 masked narrowed", 2'd2, 32'h0000_0000);
    @(negedge clk);
    chk("R8 irq dropped", {31'd0, irqOut}, 32'h0);
    doWrite(2'd0, 32'h0000_0002);
    @(negedge clk);
    chk("R8 irq with one source", {31'd0, irqOut}, 32'h1);
    genIrq = 4'b0000;
    #0.5;
    chk("R8 irq held one cycle", {31'd0, irqOut}, 32'h1);
    @(negedge clk);
    chk("R8 irq follows one cycle later", {31'd0, irqOut}, 32'h0);
  endtask

  task automatic tLatch();
    doWrite(2'd0, 32'h000F_0000);
    @(negedge clk); latchMode[0] = 1'b1; faultIn[0] = 1'b1;
    @(negedge clk); faultIn[0] = 1'b0;
    @(negedge clk);
    rdChk("R4 latched flag holds", 2'd1, 32'h0001_0000);
    rdChk("R8 masked shows fault", 2'd2, 32'h0001_0000);
    chk("R8 irq from fault", {31'd0, irqOut}, 32'h1);
    doWrite(2'd2, 32'h0000_0000);
    rdChk("R10 zero write keeps flag", 2'd1, 32'h0001_0000);
    doWrite(2'd2, 32'h0001_0000);
    rdChk("R5 clear drops flag", 2'd1, 32'h0000_0000);
  endtask

  task automatic tSetWins();
    @(negedge clk); latchMode[1] = 1'b1; faultIn[1] = 1'b1;
    doWrite(2'd2, 32'h0002_0000);
    rdChk("R9 set wins over clear", 2'd1, 32'h0002_0000);
    faultIn[1] = 1'b0;
    doWrite(2'd2, 32'h0002_0000);
    rdChk("R5 clear after fault gone", 2'd1, 32'h0000_0000);
  endtask

  task automatic tLive();
    @(negedge clk); latchMode[2] = 1'b0; faultIn[2] = 1'b1;
    rdChk("R6 live follows input", 2'd1, 32'h0004_0000);
    doWrite(2'd2, 32'h0004_0000);
    rdChk("R6 clear ignored in live mode", 2'd1, 32'h0004_0000);
    faultIn[2] = 1'b0;
    rdChk("R6 live drops with input", 2'd1, 32'h0000_0000);
  endtask

  task automatic tUnused();
    doWrite(2'd3, 32'hFFFF_FFFF);
    rdChk("R2 unused address reads zero", 2'd3, 32'h0);
    rdChk("R2 unused write leaves enable", 2'd0, 32'h000F_0000);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; regAddr = '0; wrData = '0;
    genIrq = '0; faultIn = '0; latchMode = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tGenMirror();
    tEnable();
    tLatch();
    tSetWins();
    tLive();
    tUnused();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule